// File: doc/BRIEF.md
# UART Receive Queue with Overrun Tagging

This block is the receive side of a UART peripheral. It holds up to 32 received characters, and a few status bits are stored with each one. A receiver front end pushes characters and break events into it. A register-read path pops words out of it. From its fill level the block keeps five status outputs: receive-ready, data-ready, receive-empty, a sticky overrun flag and a sticky break-detected flag. It also tells the front end, through an accept output, whether another character can be stored.

Each popped word has the following layout:

| Bit | Meaning |
|-----|---------|
| 15 | character-valid |
| 14 | error summary |
| 13 | overrun tag |
| 12 | framing error |
| 11 | break |
| 10:8 | zero |
| 7:0 | character |

Only a stored entry that sits at the head reads as a non-zero word. The character that fills the last free slot is stored with its error and overrun bits set, so software sees in the data stream where the queue ran out of room. Receive-ready rises when the fill count reaches a programmable trigger level. That level is the 6-bit field taken from the FIFO control register.

Top module: `uart_rx_queue`

## Requirements
- R1: The queue holds 32 entries. `accept` is high exactly when `rx_en` is high and fewer than 32 entries are stored.
- R2: A push while 32 entries are stored is dropped and sets `overrun`. `overrun` stays high until an `ovr_clr` pulse clears it. A set in the same cycle takes priority over the clear.
- R3: A push that finds exactly 31 entries stored writes its word with bit 14 (error) and bit 13 (overrun) set.
- R4: After every push event, `data_ready` is 1 and `rx_empty` is 0. `rx_ready` is set when the resulting count is at least `trig_level`.
- R5: A pop while the queue is empty reads `pop_word` = 0 and leaves all status outputs unchanged.
- R6: A pop of a stored entry reads that entry with bit 15 set. The pop clears `rx_ready` if the remaining count is below `trig_level`.
- R7: A pop that leaves zero entries clears `data_ready` and sets `rx_empty`.
- R8: A `push_break` stores the word 0xD800 (bits 15, 14, 12 and 11 set, character 0). It also sets `break_seen`, which stays high until a `brk_clr` pulse clears it.
- R9: While `rx_en` is low, character and break pushes are ignored.
- R10: With `trig_level` = 0, any push sets `rx_ready`. A later pop to empty does not clear it.
- R11: A push and a pop in the same cycle leave the count unchanged. The flags are evaluated on the resulting count.
- R12: Entries are popped in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable control bit |
| trig_level | input | 6 | Receive-ready fill threshold |
| push_valid | input | 1 | Push of a received character |
| push_char | input | 8 | Received character |
| push_break | input | 1 | Break event; has priority over `push_valid` |
| pop_req | input | 1 | Pop of the head entry (register read) |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| brk_clr | input | 1 | Clears the sticky break flag |
| accept | output | 1 | The front end may push a character |
| pop_word | output | 16 | Head word, or 0 when the queue is empty |
| rx_ready | output | 1 | Fill count has reached the trigger level |
| data_ready | output | 1 | At least one entry is stored |
| rx_empty | output | 1 | No entry is stored |
| overrun | output | 1 | Sticky: a push was dropped because the queue was full |
| break_seen | output | 1 | Sticky: a break event was received |

## Verification
A wrong fill count shows up at `accept` one cycle after the offending push or pop. It also shows up when the queue is drained: the number of valid words popped, or the position of the tagged word, comes out wrong. A pointer error shows in the order of the popped characters on the next read. A status register that misses a set or clear condition shows at its output on the edge that follows the event. The bench therefore checks the flags one cycle after each push or pop, and checks `pop_word` before the edge that consumes it.

// File: rtl/uart_rx_queue_pkg.sv
package uart_rx_queue_pkg;

    localparam int CHAR_W   = 8;
    localparam int WORD_W   = 16;

    localparam int BIT_VALID = 15;
    localparam int BIT_ERR   = 14;
    localparam int BIT_OVR   = 13;
    localparam int BIT_FRM   = 12;
    localparam int BIT_BRK   = 11;

    // One stored queue entry.
    typedef struct packed {
        logic              err;
        logic              ovr;
        logic              frm;
        logic              brk;
        logic [CHAR_W-1:0] ch;
    } rxq_entry_t;

    // Status outputs kept as registers.
    typedef struct packed {
        logic rdy;
        logic dr;
        logic empty;
        logic ovr;
        logic brk;
    } rxq_status_t;

    localparam rxq_status_t STATUS_RESET = '{rdy: 1'b0, dr: 1'b0, empty: 1'b1, ovr: 1'b0, brk: 1'b0};

    // Build the entry for a push. A break replaces the character.
    function automatic rxq_entry_t make_entry(logic [CHAR_W-1:0] ch, logic is_brk, logic last_slot);
        rxq_entry_t e;
        e.ch  = is_brk ? '0 : ch;
        e.brk = is_brk;
        e.frm = is_brk;
        e.ovr = last_slot;
        e.err = is_brk | last_slot;
        return e;
    endfunction

    // Expand an entry into the popped word with the valid bit set.
    function automatic logic [WORD_W-1:0] entry_to_word(rxq_entry_t e);
        logic [WORD_W-1:0] w;
        w            = '0;
        w[CHAR_W-1:0] = e.ch;
        w[BIT_VALID] = 1'b1;
        w[BIT_ERR]   = e.err;
        w[BIT_OVR]   = e.ovr;
        w[BIT_FRM]   = e.frm;
        w[BIT_BRK]   = e.brk;
        return w;
    endfunction

endpackage

// File: rtl/uart_rx_queue_store.sv
module uart_rx_queue_store
    import uart_rx_queue_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  rxq_entry_t wr_data,
    input  logic       rd_en,
    output rxq_entry_t rd_data
);

    rxq_entry_t        mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/uart_rx_queue_level.sv
module uart_rx_queue_level #(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] next_count,
    output logic             full,
    output logic             empty,
    output logic             last_slot
);

    assign next_count = count + CNT_W'(inc) - CNT_W'(dec);
    assign full       = (count == CNT_W'(DEPTH));
    assign empty      = (count == '0);
    assign last_slot  = (count == CNT_W'(DEPTH - 1));

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= next_count;
    end

endmodule

// File: rtl/uart_rx_queue_flags.sv
module uart_rx_queue_flags
    import uart_rx_queue_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int TRIG_W = 6,
    localparam int CMP_W = ((CNT_W > TRIG_W) ? CNT_W : TRIG_W) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_evt,
    input  logic              pop_ok,
    input  logic [CNT_W-1:0]  next_count,
    input  logic [TRIG_W-1:0] trig,
    input  logic              ovr_set,
    input  logic              ovr_clr,
    input  logic              brk_set,
    input  logic              brk_clr,
    output rxq_status_t       status
);

    logic [CMP_W-1:0] cnt_x;
    logic [CMP_W-1:0] trig_x;
    logic             at_level;
    rxq_status_t      nxt;

    assign cnt_x    = CMP_W'(next_count);
    assign trig_x   = CMP_W'(trig);
    assign at_level = (cnt_x >= trig_x);

    always_comb begin
        nxt = status;
        // Threshold: a pop may clear, a push may set, both use the new count.
        if (pop_ok && !at_level) nxt.rdy = 1'b0;
        if (push_evt && at_level) nxt.rdy = 1'b1;
        // Emptiness follows the resulting count.
        if (pop_ok && next_count == '0) begin
            nxt.dr    = 1'b0;
            nxt.empty = 1'b1;
        end
        if (push_evt) begin
            nxt.dr    = 1'b1;
            nxt.empty = 1'b0;
        end
        // Sticky bits: a set wins over a clear in the same cycle.
        if (ovr_clr) nxt.ovr = 1'b0;
        if (ovr_set) nxt.ovr = 1'b1;
        if (brk_clr) nxt.brk = 1'b0;
        if (brk_set) nxt.brk = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= STATUS_RESET;
        else     status <= nxt;
    end

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rx_queue_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int TRIG_W = 6,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic [TRIG_W-1:0] trig_level,
    input  logic              push_valid,
    input  logic [CHAR_W-1:0] push_char,
    input  logic              push_break,
    input  logic              pop_req,
    input  logic              ovr_clr,
    input  logic              brk_clr,
    output logic              accept,
    output logic [WORD_W-1:0] pop_word,
    output logic              rx_ready,
    output logic              data_ready,
    output logic              rx_empty,
    output logic              overrun,
    output logic              break_seen
);

    logic             push_evt;
    logic             store_ok;
    logic             pop_ok;
    logic             q_full;
    logic             q_empty;
    logic             last_slot;
    logic [CNT_W-1:0] fill_cnt;
    logic [CNT_W-1:0] fill_next;
    rxq_entry_t       new_entry;
    rxq_entry_t       head;
    rxq_status_t      status;

    // A break takes priority over a character in the same cycle.
    assign push_evt  = rx_en && (push_valid || push_break);
    assign store_ok  = push_evt && !q_full;
    assign pop_ok    = pop_req && !q_empty;
    assign new_entry = make_entry(push_char, push_break, last_slot);

    uart_rx_queue_level #(.DEPTH(DEPTH)) u_level (
        .clk        (clk),
        .rst        (rst),
        .inc        (store_ok),
        .dec        (pop_ok),
        .count      (fill_cnt),
        .next_count (fill_next),
        .full       (q_full),
        .empty      (q_empty),
        .last_slot  (last_slot)
    );

    uart_rx_queue_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (store_ok),
        .wr_data (new_entry),
        .rd_en   (pop_ok),
        .rd_data (head)
    );

    uart_rx_queue_flags #(.CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .push_evt   (push_evt),
        .pop_ok     (pop_ok),
        .next_count (fill_next),
        .trig       (trig_level),
        .ovr_set    (push_evt && q_full),
        .ovr_clr    (ovr_clr),
        .brk_set    (rx_en && push_break),
        .brk_clr    (brk_clr),
        .status     (status)
    );

    assign accept     = rx_en && !q_full;
    assign pop_word   = q_empty ? '0 : entry_to_word(head);
    assign rx_ready   = status.rdy;
    assign data_ready = status.dr;
    assign rx_empty   = status.empty;
    assign overrun    = status.ovr;
    assign break_seen = status.brk;

endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk
    import uart_rx_queue_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_en,
    input logic              push_valid,
    input logic              push_break,
    input logic              pop_req,
    input logic              accept,
    input logic [WORD_W-1:0] pop_word,
    input logic              rx_ready,
    input logic              data_ready,
    input logic              rx_empty,
    input logic              overrun,
    input logic              break_seen,
    input logic [CNT_W-1:0]  fill_cnt
);

    logic push_any;
    assign push_any = rx_en && (push_valid || push_break);

    p_full_block_r1: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt == CNT_W'(DEPTH)) |-> !accept);

    p_drop_sets_ovr_r2: assert property (@(posedge clk) disable iff (rst)
        (push_any && !accept) |=> overrun);

    p_push_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
        push_any |=> (!rx_empty && data_ready));

    p_dr_vs_empty_r4: assert property (@(posedge clk) disable iff (rst)
        data_ready != rx_empty);

    p_empty_reads_zero_r5: assert property (@(posedge clk) disable iff (rst)
        rx_empty |-> (pop_word == '0));

    p_empty_pop_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_empty && pop_req && !push_any) |=> (rx_empty && $stable(rx_ready)));

    p_valid_bit_r6: assert property (@(posedge clk) disable iff (rst)
        !rx_empty |-> pop_word[BIT_VALID]);

    p_break_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_en && push_break) |=> break_seen);

    p_disabled_r9: assert property (@(posedge clk) disable iff (rst)
        !rx_en |-> !accept);

    p_swap_count_r11: assert property (@(posedge clk) disable iff (rst)
        (push_any && accept && pop_req && !rx_empty) |=> $stable(fill_cnt));

endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .push_valid (push_valid),
    .push_break (push_break),
    .pop_req    (pop_req),
    .accept     (accept),
    .pop_word   (pop_word),
    .rx_ready   (rx_ready),
    .data_ready (data_ready),
    .rx_empty   (rx_empty),
    .overrun    (overrun),
    .break_seen (break_seen),
    .fill_cnt   (fill_cnt)
);

// File: tb/uart_rx_queue_test.sv
module uart_rx_queue_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_en = 1'b0;
    logic [5:0]  trig_level = '0;
    logic        push_valid = 1'b0;
    logic [7:0]  push_char = '0;
    logic        push_break = 1'b0;
    logic        pop_req = 1'b0;
    logic        ovr_clr = 1'b0;
    logic        brk_clr = 1'b0;
    logic        accept;
    logic [15:0] pop_word;
    logic        rx_ready, data_ready, rx_empty, overrun, break_seen;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    uart_rx_queue uut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .trig_level(trig_level),
        .push_valid(push_valid), .push_char(push_char), .push_break(push_break),
        .pop_req(pop_req), .ovr_clr(ovr_clr), .brk_clr(brk_clr),
        .accept(accept), .pop_word(pop_word), .rx_ready(rx_ready),
        .data_ready(data_ready), .rx_empty(rx_empty), .overrun(overrun),
        .break_seen(break_seen)
    );

    // Stimulus table: {kind, arg, expected rx_ready, data_ready, rx_empty}
    // kind 0 = push arg, 1 = pop expecting {8'h80, arg}, 2 = set trigger level
    localparam logic [12:0] TBL [14] = '{
        {2'd2, 8'd3,  3'b001},
        {2'd0, 8'h11, 3'b010},
        {2'd0, 8'h22, 3'b010},
        {2'd0, 8'h33, 3'b110},
        {2'd1, 8'h11, 3'b010},
        {2'd0, 8'h44, 3'b110},
        {2'd1, 8'h22, 3'b010},
        {2'd1, 8'h33, 3'b010},
        {2'd1, 8'h44, 3'b001},
        {2'd2, 8'd0,  3'b001},
        {2'd0, 8'h55, 3'b110},
        {2'd1, 8'h55, 3'b101},
        {2'd0, 8'h66, 3'b110},
        {2'd1, 8'h66, 3'b101}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        push_valid = 1'b0; push_break = 1'b0; pop_req = 1'b0;
        ovr_clr = 1'b0; brk_clr = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input logic [7:0] c);
        push_valid = 1'b1; push_char = c;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [15:0] exp);
        chk(req, pop_word, exp);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rx_en = 1'b1;
        do_reset();

        // Reset state
        chk("R1 reset accept", {15'd0, accept}, 16'd1);
        chk("R7 reset flags", {11'd0, rx_ready, data_ready, rx_empty, overrun, break_seen}, 16'b00100);
        chk("R5 reset pop_word", pop_word, 16'h0000);

        // Table walk
        for (int k = 0; k < 14; k++) begin
            case (TBL[k][12:11])
                2'd0: push(TBL[k][10:3]);
                2'd1: pop_expect("R6 R12 table pop", {8'h80, TBL[k][10:3]});
                default: begin
                    trig_level = TBL[k][8:3];
                    @(negedge clk);
                end
            endcase
            chk("R4 R6 R7 R10 table flags", {13'd0, rx_ready, data_ready, rx_empty}, {13'd0, TBL[k][2:0]});
        end

        // Fill to depth, overrun tagging, overflow drop
        do_reset();
        trig_level = 6'd40;
        for (int i = 0; i < 32; i++) begin
            chk("R1 accept while filling", {15'd0, accept}, 16'd1);
            push(8'(i));
        end
        chk("R1 accept at full", {15'd0, accept}, 16'd0);
        chk("R4 rx_ready below level 40", {15'd0, rx_ready}, 16'd0);
        chk("R2 overrun before drop", {15'd0, overrun}, 16'd0);
        push(8'hAA);
        chk("R2 overrun after drop", {15'd0, overrun}, 16'd1);
        for (int i = 0; i < 32; i++) begin
            pop_expect("R3 R12 drain", (i == 31) ? (16'hE000 | 16'(i)) : (16'h8000 | 16'(i)));
        end
        chk("R7 drained flags", {14'd0, data_ready, rx_empty}, 16'b01);
        pop_expect("R5 empty pop word", 16'h0000);
        chk("R5 empty pop flags", {13'd0, rx_ready, data_ready, rx_empty}, 16'b001);
        chk("R2 overrun still sticky", {15'd0, overrun}, 16'd1);
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        chk("R2 overrun cleared", {15'd0, overrun}, 16'd0);

        // Receiver disabled
        rx_en = 1'b0;
        #0;
        chk("R9 accept low", {15'd0, accept}, 16'd0);
        push(8'h77);
        push_break = 1'b1; @(negedge clk); push_break = 1'b0;
        chk("R9 still empty", {14'd0, rx_empty, break_seen}, 16'b10);
        rx_en = 1'b1;
        chk("R9 nothing stored", pop_word, 16'h0000);

        // Break event
        push_break = 1'b1; @(negedge clk); push_break = 1'b0;
        chk("R8 break_seen set", {15'd0, break_seen}, 16'd1);
        pop_expect("R8 break word", 16'hD800);
        brk_clr = 1'b1; @(negedge clk); brk_clr = 1'b0;
        chk("R8 break_seen cleared", {15'd0, break_seen}, 16'd0);

        // Simultaneous push and pop
        do_reset();
        trig_level = 6'd2;
        push(8'hA1);
        push(8'hA2);
        chk("R4 ready at level 2", {15'd0, rx_ready}, 16'd1);
        chk("R11 head before swap", pop_word, 16'h80A1);
        push_valid = 1'b1; push_char = 8'hA3; pop_req = 1'b1;
        @(negedge clk);
        push_valid = 1'b0; pop_req = 1'b0;
        chk("R11 flags after swap", {13'd0, rx_ready, data_ready, rx_empty}, 16'b110);
        pop_expect("R11 second entry", 16'h80A2);
        chk("R6 ready cleared below level", {15'd0, rx_ready}, 16'd0);
        pop_expect("R11 pushed entry", 16'h80A3);
        chk("R7 empty after swap drain", {15'd0, rx_empty}, 16'd1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule